// File: doc/BRIEF.md
# Address Translation Cache with Permission Check

This block is a small fully associative cache of address translations for one pipeline port. Each lookup presents a virtual address, an address space identifier (ASID) and an access kind (instruction fetch, load or store). The block compares the virtual page number and ASID against every stored entry in the same cycle. A matching entry then goes through a permission check. If the check passes, the block returns a physical address built from the stored frame number and the untouched page offset. If it fails, the block reports a protection fault and returns no address. If nothing matches, the block asks an external page table walker for the translation.

When the walk finishes, the walker writes the result back in a single cycle. A resident page is written into an entry, so the retried access hits. A non-resident page writes nothing and raises a page fault pulse one cycle later, so the pipeline can take a restartable exception. Entries from different address spaces live side by side, so a context switch needs no flush. Software can drop the entries of one ASID, or drop every entry.

Top module: `tlb_prot`

## Requirements
- R1: After reset no entry is valid. Every lookup misses until a refill has been written.
- R2: A lookup hits when a valid entry holds the same ASID and virtual page number and the access is permitted. `hit_o` is 1 and `paddr_o` equals the stored frame number concatenated with the 12-bit page offset of the request.
- R3: Permission bits are bit 0 read, bit 1 write and bit 2 execute. The access code is 0 fetch (needs execute), 1 load (needs read), 2 store (needs write) and 3 reserved (always denied). A matching but denied access raises `prot_fault_o`, with `hit_o` at 0 and `paddr_o` at 0.
- R4: When no valid entry matches, `walk_req_o` is 1 and `walk_vpn_o` carries the requested page number.
- R5: A refill with `refill_ok_i`=1 is written at one clock edge, and a lookup in the following cycle hits or faults according to the new entry.
- R6: A refill with `refill_ok_i`=0 writes no entry. It drives `page_fault_o` high for exactly the next cycle.
- R7: An entry matches only a request with its own ASID, and the same page number may be held under two ASIDs at once with different frames.
- R8: A successful refill goes into the lowest-numbered invalid entry whenever one exists, and the replacement pointer does not move.
- R9: When all entries are valid, a refill replaces the entry at a round-robin pointer. The pointer starts at 0 after reset, moves up by one after each such refill and wraps after the last entry.
- R10: A pulse on `flush_asid_i` invalidates exactly the entries whose ASID equals `flush_id_i` and leaves all others intact.
- R11: A pulse on `flush_all_i` invalidates every entry.
- R12: At most one of `hit_o`, `prot_fault_o` and `walk_req_o` is high, and all three are 0 while `req_valid_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_vaddr_i | input | 32 | Virtual address (page number and 12-bit offset) |
| req_asid_i | input | 8 | Address space of the request |
| req_acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| hit_o | output | 1 | Translation found and permitted |
| paddr_o | output | 32 | Physical address, valid with hit_o |
| prot_fault_o | output | 1 | Translation found but access denied |
| walk_req_o | output | 1 | No translation; walk needed |
| walk_vpn_o | output | 20 | Page number to walk |
| refill_valid_i | input | 1 | Walk result present |
| refill_ok_i | input | 1 | Page resident (1) or not resident (0) |
| refill_asid_i | input | 8 | ASID of the walked page |
| refill_vpn_i | input | 20 | Walked page number |
| refill_ppn_i | input | 20 | Frame number from the walk |
| refill_perm_i | input | 3 | Permissions {X, W, R} |
| page_fault_o | output | 1 | Pulse one cycle after a non-resident walk result |
| flush_asid_i | input | 1 | Invalidate entries of one ASID |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_id_i | input | 8 | ASID selected for the flush |

## Verification
The assertions assume that the walker only refills a page that is not already cached under the same ASID, so that at most one entry can match. They also assume that a flush and a refill never arrive in the same cycle. The stimulus keeps to both assumptions. Every refill uses a page/ASID pair that is absent from the bench's model, and flushes and refills are issued on separate clock edges. After every state change, the bench sweeps every stored entry with all four access codes, under both its own ASID and a foreign one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
  localparam int PERM_BITS = 3;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N_ENTRY = 8,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic [N_ENTRY-1:0]             valid_i,
  input  logic [N_ENTRY-1:0][ASID_W-1:0] asid_tbl_i,
  input  logic [N_ENTRY-1:0][VPN_W-1:0]  vpn_tbl_i,
  input  logic [ASID_W-1:0]              asid_i,
  input  logic [VPN_W-1:0]               vpn_i,
  output logic [N_ENTRY-1:0]             hit_vec_o,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               hit_idx_o
);
  for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (asid_tbl_i[g] == asid_i) && (vpn_tbl_i[g] == vpn_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N_ENTRY = 8,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_ENTRY-1:0] valid_i,
  input  logic               alloc_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  // lowest invalid slot wins
  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign victim_o = free_found ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (alloc_i && !free_found) begin
      rr_q <= (rr_q == IDX_W'(N_ENTRY - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  p_victim_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&valid_i)) |-> !valid_i[victim_o]);

  p_rr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !(&valid_i)) |=> $stable(rr_q));

  p_rr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && (&valid_i) && rr_q != IDX_W'(N_ENTRY - 1)) |=> rr_q == $past(rr_q) + 1'b1);
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [1:0]           acc_i,
  input  logic [PERM_BITS-1:0] perm_i,
  output logic                 ok_o
);
  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_FETCH: ok_o = perm_i[PERM_X];
      ACC_LOAD:  ok_o = perm_i[PERM_R];
      ACC_STORE: ok_o = perm_i[PERM_W];
      default:   ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
  import tlb_pkg::*;
#(
  parameter int N_ENTRY = 8,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [VA_W-1:0]      req_vaddr_i,
  input  logic [ASID_W-1:0]    req_asid_i,
  input  logic [1:0]           req_acc_i,
  output logic                 hit_o,
  output logic [PA_W-1:0]      paddr_o,
  output logic                 prot_fault_o,
  output logic                 walk_req_o,
  output logic [VPN_W-1:0]     walk_vpn_o,
  input  logic                 refill_valid_i,
  input  logic                 refill_ok_i,
  input  logic [ASID_W-1:0]    refill_asid_i,
  input  logic [VPN_W-1:0]     refill_vpn_i,
  input  logic [PPN_W-1:0]     refill_ppn_i,
  input  logic [PERM_BITS-1:0] refill_perm_i,
  output logic                 page_fault_o,
  input  logic                 flush_asid_i,
  input  logic                 flush_all_i,
  input  logic [ASID_W-1:0]    flush_id_i
);
  logic [N_ENTRY-1:0]                valid_q;
  logic [N_ENTRY-1:0][ASID_W-1:0]    asid_q;
  logic [N_ENTRY-1:0][VPN_W-1:0]     vpn_q;
  logic [N_ENTRY-1:0][PPN_W-1:0]     ppn_q;
  logic [N_ENTRY-1:0][PERM_BITS-1:0] perm_q;
  logic                              pf_q;

  logic [VPN_W-1:0]   look_vpn;
  logic [OFF_W-1:0]   look_off;
  logic [N_ENTRY-1:0] hit_vec;
  logic               tag_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic               perm_ok;
  logic               alloc;
  logic [IDX_W-1:0]   victim;

  assign look_vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign look_off = req_vaddr_i[OFF_W-1:0];
  assign alloc    = refill_valid_i && refill_ok_i;

  tlb_match #(.N_ENTRY(N_ENTRY), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_match (
    .valid_i    (valid_q),
    .asid_tbl_i (asid_q),
    .vpn_tbl_i  (vpn_q),
    .asid_i     (req_asid_i),
    .vpn_i      (look_vpn),
    .hit_vec_o  (hit_vec),
    .hit_o      (tag_hit),
    .hit_idx_o  (hit_idx)
  );

  tlb_perm u_perm (
    .acc_i  (req_acc_i),
    .perm_i (perm_q[hit_idx]),
    .ok_o   (perm_ok)
  );

  tlb_victim #(.N_ENTRY(N_ENTRY)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_q),
    .alloc_i  (alloc),
    .victim_o (victim)
  );

  assign hit_o        = req_valid_i && tag_hit && perm_ok;
  assign prot_fault_o = req_valid_i && tag_hit && !perm_ok;
  assign walk_req_o   = req_valid_i && !tag_hit;
  assign walk_vpn_o   = walk_req_o ? look_vpn : '0;
  assign paddr_o      = hit_o ? {ppn_q[hit_idx], look_off} : '0;
  assign page_fault_o = pf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      asid_q  <= '0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      perm_q  <= '0;
      pf_q    <= 1'b0;
    end else begin
      pf_q <= refill_valid_i && !refill_ok_i;
      for (int i = 0; i < N_ENTRY; i++) begin
        if (flush_all_i || (flush_asid_i && asid_q[i] == flush_id_i)) valid_q[i] <= 1'b0;
      end
      // refill lands after any flush of the same cycle
      if (alloc) begin
        valid_q[victim] <= 1'b1;
        asid_q[victim]  <= refill_asid_i;
        vpn_q[victim]   <= refill_vpn_i;
        ppn_q[victim]   <= refill_ppn_i;
        perm_q[victim]  <= refill_perm_i;
      end
    end
  end

  p_single_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  p_one_outcome_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, prot_fault_o, walk_req_o}) && (req_valid_i || !(hit_o || prot_fault_o || walk_req_o)));

  p_refill_written_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |=> valid_q[$past(victim)] && vpn_q[$past(victim)] == $past(refill_vpn_i)
              && asid_q[$past(victim)] == $past(refill_asid_i));

  p_page_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_valid_i && !refill_ok_i) |=> page_fault_o);

  p_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc) |=> (valid_q & ~$past(valid_q)) == '0);

  p_flush_all_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && !refill_valid_i) |=> valid_q == '0);

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_flush_chk
    p_flush_asid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_asid_i && !refill_valid_i && asid_q[g] == flush_id_i) |=> !valid_q[g]);
    p_flush_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_asid_i && !flush_all_i && valid_q[g] && asid_q[g] != flush_id_i) |=> valid_q[g]);
  end
endmodule

// File: tb/tlb_prot_tb.sv
module tlb_prot_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_asid = '0;
  logic [1:0]  req_acc = '0;
  logic        hit, prot_fault, walk_req, page_fault;
  logic [31:0] paddr;
  logic [19:0] walk_vpn;
  logic        refill_valid = 1'b0, refill_ok = 1'b0;
  logic [7:0]  refill_asid = '0;
  logic [19:0] refill_vpn = '0, refill_ppn = '0;
  logic [2:0]  refill_perm = '0;
  logic        flush_asid = 1'b0, flush_all = 1'b0;
  logic [7:0]  flush_id = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model
  bit          m_valid [N];
  logic [7:0]  m_asid  [N];
  logic [19:0] m_vpn   [N];
  logic [19:0] m_ppn   [N];
  logic [2:0]  m_perm  [N];
  int          m_rr = 0;

  always #2 clk = ~clk;

  tlb_prot u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_asid_i(req_asid), .req_acc_i(req_acc),
    .hit_o(hit), .paddr_o(paddr), .prot_fault_o(prot_fault), .walk_req_o(walk_req), .walk_vpn_o(walk_vpn),
    .refill_valid_i(refill_valid), .refill_ok_i(refill_ok), .refill_asid_i(refill_asid),
    .refill_vpn_i(refill_vpn), .refill_ppn_i(refill_ppn), .refill_perm_i(refill_perm),
    .page_fault_o(page_fault),
    .flush_asid_i(flush_asid), .flush_all_i(flush_all), .flush_id_i(flush_id)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit perm_ok(logic [2:0] p, int acc);
    case (acc)
      0: return p[2];
      1: return p[0];
      2: return p[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic look(string tag, logic [7:0] asid, logic [19:0] vpn, logic [11:0] off, int acc);
    int k = -1;
    bit e_hit, e_pf, e_walk;
    logic [31:0] e_pa;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_asid[i] == asid && m_vpn[i] == vpn) k = i;
    e_hit  = (k >= 0) && perm_ok(m_perm[k], acc);
    e_pf   = (k >= 0) && !perm_ok(m_perm[k], acc);
    e_walk = (k < 0);
    e_pa   = e_hit ? {m_ppn[k], off} : 32'h0;
    req_valid = 1'b1; req_asid = asid; req_vaddr = {vpn, off}; req_acc = 2'(acc);
    #0.5;
    chk({tag, " out"}, {61'h0, hit, prot_fault, walk_req}, {61'h0, e_hit, e_pf, e_walk});
    chk({tag, " addr"}, {12'h0, walk_vpn, paddr}, {12'h0, (e_walk ? vpn : 20'h0), e_pa});
    req_valid = 1'b0;
    #0.5;
  endtask

  task automatic sweep(string tag);
    for (int e = 0; e < N; e++) begin
      if (m_valid[e]) begin
        for (int a = 0; a < 4; a++) begin
          look({tag, (a == 3) ? " R3" : (perm_ok(m_perm[e], a) ? " R2" : " R3")},
               m_asid[e], m_vpn[e], 12'(12'h5a3 ^ (e * 37 + a)), a);
          look({tag, " R7"}, m_asid[e] + 8'd9, m_vpn[e], 12'h0ff, a);
        end
      end
    end
    look({tag, " R4"}, 8'd1, 20'hfffff, 12'h123, 1);
  endtask

  task automatic refill(logic [7:0] asid, logic [19:0] vpn, logic [19:0] ppn, logic [2:0] perm, bit ok);
    int v = -1;
    @(negedge clk);
    refill_valid = 1'b1; refill_ok = ok; refill_asid = asid;
    refill_vpn = vpn; refill_ppn = ppn; refill_perm = perm;
    @(negedge clk);
    refill_valid = 1'b0;
    if (ok) begin
      for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) v = i;
      if (v < 0) begin
        v = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_valid[v] = 1'b1; m_asid[v] = asid; m_vpn[v] = vpn; m_ppn[v] = ppn; m_perm[v] = perm;
      chk("R6 no pf on good refill", {63'h0, page_fault}, 64'h0);
    end else begin
      chk("R6 page fault pulse", {63'h0, page_fault}, 64'h1);
      @(negedge clk);
      chk("R6 pulse one cycle", {63'h0, page_fault}, 64'h0);
    end
  endtask

  task automatic flush(bit all, logic [7:0] id);
    @(negedge clk);
    flush_all = all; flush_asid = !all; flush_id = id;
    @(negedge clk);
    flush_all = 1'b0; flush_asid = 1'b0;
    for (int i = 0; i < N; i++) if (all || m_asid[i] == id) m_valid[i] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_asid[i] = '0; m_vpn[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle outputs", {57'h0, hit, prot_fault, walk_req, page_fault, 3'h0}, 64'h0);
    chk("R1 reset addr", {12'h0, walk_vpn, paddr}, 64'h0);
    look("R1 reset miss", 8'd0, 20'h0, 12'h0, 0);
    look("R1 reset miss", 8'd1, 20'h100, 12'h7ff, 2);

    // fill all slots, perm = slot index covers all 8 combinations (R5, R8)
    for (int i = 0; i < N; i++) begin
      refill((i % 2 == 0) ? 8'd1 : 8'd2, 20'h100 + 20'(i), 20'ha000 + 20'(i * 3), 3'(i), 1'b1);
      look("R5 retry", (i % 2 == 0) ? 8'd1 : 8'd2, 20'h100 + 20'(i), 12'h010, 1);
      sweep("R8 fill");
    end

    // full: round robin from slot 0 (R9)
    refill(8'd3, 20'h200, 20'hb000, 3'b111, 1'b1);
    look("R9 slot0 evicted", 8'd1, 20'h100, 12'h0, 1);
    look("R9 new entry", 8'd3, 20'h200, 12'habc, 0);
    refill(8'd3, 20'h201, 20'hb001, 3'b011, 1'b1);
    look("R9 slot1 evicted", 8'd2, 20'h101, 12'h0, 1);
    sweep("R9");

    // same page under another ASID (R7)
    refill(8'd4, 20'h200, 20'hc000, 3'b001, 1'b1);
    look("R7 asid3 frame", 8'd3, 20'h200, 12'h055, 1);
    look("R7 asid4 frame", 8'd4, 20'h200, 12'h055, 1);
    look("R7 asid4 store", 8'd4, 20'h200, 12'h055, 2);
    sweep("R7");

    // ASID flush (R10), then lowest free slot (R8)
    flush(1'b0, 8'd1);
    sweep("R10");
    look("R10 asid1 gone", 8'd1, 20'h104, 12'h0, 1);
    look("R10 asid2 kept", 8'd2, 20'h103, 12'h0, 0);
    refill(8'd5, 20'h300, 20'hd000, 3'b110, 1'b1);
    refill(8'd5, 20'h301, 20'hd001, 3'b101, 1'b1);
    sweep("R8 reuse");
    refill(8'd5, 20'h302, 20'hd002, 3'b111, 1'b1);
    refill(8'd5, 20'h303, 20'hd003, 3'b111, 1'b1);
    sweep("R9 resume");

    // non-resident page (R6)
    refill(8'd6, 20'h400, 20'he000, 3'b111, 1'b0);
    look("R6 nothing written", 8'd6, 20'h400, 12'h0, 1);
    sweep("R6");

    // global flush (R11)
    flush(1'b1, 8'd0);
    look("R11 all gone", 8'd3, 20'h200, 12'h0, 1);
    look("R11 all gone", 8'd5, 20'h303, 12'h0, 1);
    sweep("R11");
    refill(8'd7, 20'h500, 20'hf000, 3'b100, 1'b1);
    sweep("R8 after flush");

    @(negedge clk);
    chk("R12 idle end", {61'h0, hit, prot_fault, walk_req}, 64'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule